// File: doc/BRIEF.md
# 64B/66B Transmit Gearbox

This block sits between a block-coded data source and a fixed-width serializer. Each 64-bit payload block travels with a 2-bit sync header. The block merges the headers and payloads into one continuous bit stream and cuts that stream into output words of the input width. The width is 32 bits or 16 bits, chosen by a parameter.

Each block is 66 bits wide but arrives as 64 bits of payload. The output therefore gains two bits per block that the source never supplies. The block keeps a free-running sequence count and, once per period, lowers a ready flag so that the source pauses for exactly the cycles the output needs to drain the collected header bits.

Counting starts only when the source raises a start strobe together with its first valid word. Until then the block stays idle for as long as the strobe stays low. After the strobe, the output word is valid on every cycle.

Top module: `tx_gearbox66`

## Requirements
- R1: `DATA_W` sets both the input and the output word width, and must be 32 or 16. The header input is 3 bits wide. Only header bits [1:0] are transmitted, and header bit 2 never affects the output.
- R2: Reset is synchronous and active high. While reset is high, `tx_ready` is 1. From the first clock edge with reset high, `out_valid` is 0 and `out_word` is 0.
- R3: After reset and before the start strobe, data and header inputs are ignored, `out_valid` stays 0, `out_word` stays 0 and `tx_ready` stays 1. The idle wait may be any length and leaves no residue behind.
- R4: The word presented in the cycle where `tx_start` is first 1 is the first accepted word, and it is the first word of a block. `out_valid` rises on the next clock edge. Later values of `tx_start` are ignored until the next reset.
- R5: The transmitted bit order is header bit 0, header bit 1, then payload bits. Within a block the payload runs from the first word to the last, each word starting at bit 0. `out_word` bit 0 is the earliest bit. Each output word leaves the block one register after the cycle in which its last bit was accepted.
- R6: A period is 33 cycles in which 32 words are accepted when `DATA_W`=32, or 66 cycles in which 64 words are accepted when `DATA_W`=16. A header is taken with the first word of every block, which is every 2nd accepted word at 32 bits and every 4th at 16 bits.
- R7: In every period `tx_ready` is low for exactly 2 consecutive cycles when `DATA_W`=32, and for exactly 3 when `DATA_W`=16. The first low cycle is the last accepting cycle of the period.
- R8: The word presented in the cycle where `tx_ready` falls is still accepted. Data presented in the following 1 (32-bit) or 2 (16-bit) cycles is ignored. `tx_ready` returns to 1 in the cycle whose word is accepted next.
- R9: The header input is also ignored during the paused cycles, so it need not be held.
- R10: Once `out_valid` is 1 it stays 1 on every cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_W | Payload word from the source |
| tx_hdr | input | 3 | Sync header; bits [1:0] are used |
| tx_start | input | 1 | Marks the first valid word after reset |
| tx_ready | output | 1 | Low when the source must pause |
| out_word | output | DATA_W | Packed output word |
| out_valid | output | 1 | Output word valid |

## Verification
The bench targets the period wrap, where a counter off by one would move the hold point. That would show up as a ready pause of the wrong length, or as a word accepted or dropped at the pause, and either one shifts every later output bit. It drives random data and headers with bit 2 set during pauses and during the idle wait, so a design that samples them would corrupt the stream. Resets in the middle of a period and idle waits of different lengths, including none, expose a design that keeps residue bits or starts counting before the strobe. The bench repeats the start strobe after the first word, which catches a design that restarts the sequence.

// File: rtl/gb66_pkg.sv
package gb66_pkg;

  localparam int PAY_BITS       = 64;
  localparam int SYNC_BITS      = 2;
  localparam int BLKS_PER_CYCLE = 16;

  // accepting cycles per period
  function automatic int acc_cycles(input int w);
    return (BLKS_PER_CYCLE * PAY_BITS) / w;
  endfunction

  // pause cycles per period: enough to drain the collected sync bits
  function automatic int hold_cycles(input int w);
    return (BLKS_PER_CYCLE * SYNC_BITS) / w;
  endfunction

  function automatic int period_len(input int w);
    return acc_cycles(w) + hold_cycles(w);
  endfunction

  function automatic int words_per_blk(input int w);
    return PAY_BITS / w;
  endfunction

  // bits held in the residue register at the start of sequence step s
  function automatic int res_bits(input int s, input int w);
    int acc;
    int wpb;
    int sc;
    int drained;
    acc     = acc_cycles(w);
    wpb     = words_per_blk(w);
    sc      = (s > acc) ? acc : s;
    drained = (s > acc) ? w * (s - acc) : 0;
    return SYNC_BITS * ((sc + wpb - 1) / wpb) - drained;
  endfunction

endpackage

// File: rtl/gb66_seq_ctrl.sv
module gb66_seq_ctrl #(
  parameter int DATA_W = 32,
  parameter int SEQ_W  = $clog2(gb66_pkg::period_len(DATA_W))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic [SEQ_W-1:0] seq_o,
  output logic             active_o,
  output logic             accept_o,
  output logic             hdr_slot_o,
  output logic             ready_o,
  output logic             started_o
);
  localparam int ACC    = gb66_pkg::acc_cycles(DATA_W);
  localparam int HOLD   = gb66_pkg::hold_cycles(DATA_W);
  localparam int PERIOD = gb66_pkg::period_len(DATA_W);
  localparam int WPB    = gb66_pkg::words_per_blk(DATA_W);
  localparam int WPB_LG = $clog2(WPB);

  logic             started_q;
  logic [SEQ_W-1:0] seq_q;
  logic             wrap;
  logic [SEQ_W-1:0] low_run_q;

  assign active_o  = started_q | start_i;
  assign wrap      = (seq_q == SEQ_W'(PERIOD - 1));
  assign accept_o  = active_o && (seq_q < SEQ_W'(ACC));
  assign seq_o     = seq_q;
  assign started_o = started_q;

  generate
    if (WPB_LG > 0) begin : g_multi_word_blk
      assign hdr_slot_o = accept_o && (seq_q[WPB_LG-1:0] == '0);
    end else begin : g_single_word_blk
      assign hdr_slot_o = accept_o;
    end
  endgenerate

  assign ready_o = rst || !(started_q && (seq_q >= SEQ_W'(ACC - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      seq_q     <= '0;
    end else if (active_o) begin
      started_q <= 1'b1;
      seq_q     <= wrap ? '0 : seq_q + 1'b1;
    end
  end

  // length of the current low run of ready, watched by the assertions
  always_ff @(posedge clk) begin
    if (rst || ready_o) low_run_q <= '0;
    else                low_run_q <= low_run_q + 1'b1;
  end

  AST_LOW_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> low_run_q == SEQ_W'(HOLD + 1)); // R7
  AST_FALL_STILL_TAKES: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> accept_o); // R8
  AST_FALL_THEN_PAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |=> !accept_o); // R8
  AST_RISE_RESUMES: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> accept_o); // R8
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> ready_o); // R3

endmodule

// File: rtl/gb66_packer.sv
module gb66_packer #(
  parameter int DATA_W = 32,
  parameter int SEQ_W  = $clog2(gb66_pkg::period_len(DATA_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              accept_i,
  input  logic              hdr_slot_i,
  input  logic [SEQ_W-1:0]  seq_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        hdr_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o
);
  localparam int RES_W = gb66_pkg::BLKS_PER_CYCLE * gb66_pkg::SYNC_BITS;
  localparam int IN_W  = DATA_W + gb66_pkg::SYNC_BITS;
  localparam int BUF_W = RES_W + IN_W;
  localparam int LEN_W = $clog2(BUF_W + 1);

  logic [RES_W-1:0] res_q;
  logic [LEN_W-1:0] rlen;
  logic [IN_W-1:0]  in_bits;
  logic [BUF_W-1:0] merged;
  logic [BUF_W-1:0] shifted;

  assign rlen = LEN_W'(gb66_pkg::res_bits(int'(seq_i), DATA_W));

  always_comb begin
    if (hdr_slot_i)    in_bits = {data_i, hdr_i};
    else if (accept_i) in_bits = {2'b00, data_i};
    else               in_bits = '0;
  end

  assign merged  = BUF_W'(res_q) | (BUF_W'(in_bits) << rlen);
  assign shifted = merged >> DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else if (active_i) begin
      res_q   <= shifted[RES_W-1:0];
      word_o  <= merged[DATA_W-1:0];
      valid_o <= 1'b1;
    end
  end

  AST_RES_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (res_q >> rlen) == '0); // R5
  AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (rst)
    (active_i && !accept_i) |-> rlen >= LEN_W'(DATA_W)); // R6
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o); // R10
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> $stable(res_q)); // R3

endmodule

// File: rtl/tx_gearbox66.sv
module tx_gearbox66 #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [2:0]        tx_hdr,
  input  logic              tx_start,
  output logic              tx_ready,
  output logic [DATA_W-1:0] out_word,
  output logic              out_valid
);
  localparam int SEQ_W = $clog2(gb66_pkg::period_len(DATA_W));

  logic [SEQ_W-1:0] seq;
  logic             active;
  logic             accept;
  logic             hdr_slot;
  logic             started;
  logic             unused_hdr_msb;

  assign unused_hdr_msb = tx_hdr[2];

  initial begin
    AST_WIDTH_LEGAL: assert (DATA_W == 32 || DATA_W == 16); // R1
  end

  gb66_seq_ctrl #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (tx_start),
    .seq_o      (seq),
    .active_o   (active),
    .accept_o   (accept),
    .hdr_slot_o (hdr_slot),
    .ready_o    (tx_ready),
    .started_o  (started)
  );

  gb66_packer #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) i_pack (
    .clk        (clk),
    .rst        (rst),
    .active_i   (active),
    .accept_i   (accept),
    .hdr_slot_i (hdr_slot),
    .seq_i      (seq),
    .data_i     (tx_data),
    .hdr_i      (tx_hdr[1:0]),
    .word_o     (out_word),
    .valid_o    (out_valid)
  );

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (!started && !tx_start) |=> !out_valid); // R3
  AST_START_VALID: assert property (@(posedge clk) disable iff (rst)
    (!started && tx_start) |=> out_valid); // R4

endmodule

// File: tb/test_tx_gearbox66.sv
module test_tx_gearbox66;
  localparam int DW   = 32;
  localparam int ACC  = 1024 / DW;
  localparam int HOLD = 32 / DW;
  localparam int PER  = ACC + HOLD;
  localparam int WPB  = 64 / DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] tx_data = '0;
  logic [2:0]    tx_hdr = '0;
  logic          tx_start = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] out_word;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit            m_started;
  int            m_seq;
  bit            q[$];
  logic [DW-1:0] exp_word;
  bit            exp_valid;

  always #2 clk = ~clk;

  tx_gearbox66 #(.DATA_W(DW)) i_tx_gearbox66 (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_hdr(tx_hdr),
    .tx_start(tx_start), .tx_ready(tx_ready),
    .out_word(out_word), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_ready();
    return !(m_started && m_seq >= ACC - 1);
  endfunction

  task automatic model_clear();
    m_started = 0;
    m_seq     = 0;
    q.delete();
    exp_word  = '0;
    exp_valid = 0;
  endtask

  // one clock: check last results, drive new inputs, advance the reference
  task automatic step(input logic [DW-1:0] d, input logic [2:0] h, input bit s);
    bit act;
    @(negedge clk);
    chk(out_valid == exp_valid, m_started ? "R10 R4 valid" : "R3 idle valid",
        64'(out_valid), 64'(exp_valid));
    chk(out_word == exp_word, m_started ? "R5 R6 R8 R9 R1 word" : "R3 idle word",
        64'(out_word), 64'(exp_word));
    chk(tx_ready == ref_ready(), m_started ? "R7 R8 ready" : "R3 idle ready",
        64'(tx_ready), 64'(ref_ready()));
    tx_data  = d;
    tx_hdr   = h;
    tx_start = s;
    act = m_started || s;
    if (act) begin
      if (m_seq < ACC) begin
        if (m_seq % WPB == 0) begin
          q.push_back(h[0]);
          q.push_back(h[1]);
        end
        for (int i = 0; i < DW; i++) q.push_back(d[i]);
      end
      for (int i = 0; i < DW; i++) exp_word[i] = q.pop_front();
      exp_valid = 1;
      m_started = 1;
      m_seq     = (m_seq + 1) % PER;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tx_start = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2 ready in reset", 64'(tx_ready), 64'd1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 valid in reset", 64'(out_valid), 64'd0);
    chk(out_word == '0, "R2 word in reset", 64'(out_word), 64'd0);
    chk(tx_ready == 1'b1, "R2 ready in reset", 64'(tx_ready), 64'd1);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(DW'($urandom), 3'($urandom), 1'b0);
  endtask

  task automatic run(input int n, input bit first_start);
    step(DW'($urandom), 3'($urandom), first_start);
    for (int i = 1; i < n; i++) step(DW'($urandom), 3'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    do_reset();
    // start at once, strobe toggles randomly afterwards (R4)
    run(2 * PER + 5, 1'b1);
    // reset in mid period, then long idle (R2, R3)
    do_reset();
    idle(37);
    run(3 * PER, 1'b1);
    // directed: header bit 2 set, all-ones and alternating data (R1, R9)
    do_reset();
    idle(1);
    step({DW{1'b1}}, 3'b110, 1'b1);
    for (int i = 1; i < 2 * PER; i++)
      step((i % 2 == 0) ? {DW/2{2'b10}} : {DW{1'b0}}, (i % 3 == 0) ? 3'b101 : 3'b110, 1'b1);
    // random phases
    for (int k = 0; k < 6; k++) begin
      do_reset();
      idle(int'($urandom % 50));
      run(PER + int'($urandom % (3 * PER)), 1'b1);
    end
    do_reset();
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule